// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire (I2C-style) serial link in front of a 256-byte, byte-wide storage array. It runs on a fast system clock, samples the SCL and SDA lines through synchronisers, and finds start and stop conditions and SCL edges from the sampled levels. A controller on the bus addresses the target with a device address byte. That byte holds a fixed type prefix, three strap bits that must equal the strap inputs, and a read/write bit. The target answers by pulling SDA low through an open-drain enable output.

The target supports single-byte and page writes, current-address reads, random reads and sequential reads. Written bytes collect in an 8-byte page buffer. The stop condition commits them into the array during a self-timed busy period, whose length is a parameter in clock cycles. While that period runs, the target stays off the bus. A write-protect input blocks every update to the array. An internal address counter keeps its value between transfers. During writes it wraps inside the current page. During reads it wraps across the whole array.

Top module: `twi_eeprom_target`

## Requirements
- R1: A device address byte is accepted when bits 7:4 equal 1010 and bits 3:1 equal the strap input, with bit 0 = 1 for a read and 0 for a write. The target acknowledges it by pulling SDA low during the ninth SCL clock.
- R2: A device address byte that does not match gets no acknowledge. SDA then stays released for the rest of the transfer, until the next start condition.
- R3: In a write transfer, the byte after the device address loads the internal address counter. A repeated start followed by a read device address then returns data from that address (random read).
- R4: Each data byte of a write is stored at the counter address, and only counter bits 2:0 then increment. After address offset 7 of a page, the next byte goes to offset 0 of the same page, so a ninth byte overwrites the first.
- R5: Only a stop condition commits buffered write data, and only when at least one data byte was taken. The commit starts a busy period of BUSY_CYC clock cycles. During that period a matching device address is not acknowledged.
- R6: In a read, the target sends each byte MSB first and then increments the counter across page boundaries, wrapping from 255 to 0. It sends another byte after each controller acknowledge (SDA low) and releases SDA after a no-acknowledge (SDA high).
- R7: A read that starts without a word address returns the byte at the counter, which holds the last accessed address plus one. The counter keeps its value across stop conditions.
- R8: While the write-protect input is high, the target still acknowledges the device address and the word address. It does not acknowledge data bytes, and it leaves the array unchanged.
- R9: A start condition in any state abandons the current transfer, drops any uncommitted write data and begins decoding a new device address.
- R10: After reset, SDA is released and the target is idle and not busy.
- R11: The target changes its SDA drive only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (resolved bus) |
| strap_i | input | 3 | Strap address bits compared against device address bits 3:1 |
| wp_i | input | 1 | Write protect; high blocks array updates |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The assertions assume a well-behaved controller. It changes SDA only while SCL is low, except when it makes a start or stop, and it makes a start or stop only while the target has SDA released. Each SCL phase also lasts far longer than the three-register sampling path. The bench drives SCL at a quarter period of several system clocks. It moves its own SDA only in the low phase of SCL, and it issues starts and stops only after the target has released the line after an acknowledge. Random write lengths go past the page size to exercise wrapping, and random read bursts cross page boundaries and the end of the array.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] TYPE_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_WADR,
    ST_ACK_WADR,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RDAT,
    ST_RACK,
    ST_IGNORE
  } twi_state_t;
endpackage

// File: rtl/twi_bus_sense.sv
module twi_bus_sense (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, sda_m, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      {scl_m, scl_s, scl_p} <= 3'b111;
      {sda_m, sda_s, sda_p} <= 3'b111;
    end else begin
      {scl_m, scl_s, scl_p} <= {scl_i, scl_m, scl_s};
      {sda_m, sda_s, sda_p} <= {sda_i, sda_m, sda_s};
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_eeprom_mem.sv
module twi_eeprom_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PW       = 3,
  parameter int BUSY_CYC = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_in,
  input  logic [2:0]        strap,
  input  logic              wp,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              we,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              busy
);
  localparam int PAGE     = 1 << PW;
  localparam int BUSY_EFF = (BUSY_CYC < PAGE + 1) ? PAGE + 1 : BUSY_CYC;
  localparam int BW       = $clog2(BUSY_EFF + 1);

  twi_state_t         st;
  logic [3:0]         cnt;
  logic [BYTE_W-1:0]  sr, tx;
  logic [AW-1:0]      addr;
  logic               rw, mack;
  logic [BYTE_W-1:0]  pbuf [PAGE];
  logic [PAGE-1:0]    pvalid;
  logic [BW-1:0]      bcnt;
  logic [PW:0]        cidx;
  logic               dev_match;

  assign busy      = (bcnt != '0);
  assign dev_match = (sr[7:4] == TYPE_PREFIX) && (sr[3:1] == strap) && !busy;
  assign rd_addr   = addr;
  assign we        = busy && !cidx[PW] && pvalid[cidx[PW-1:0]];
  assign wr_addr   = {addr[AW-1:PW], cidx[PW-1:0]};
  assign wr_data   = pbuf[cidx[PW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      sr     <= '0;
      tx     <= '0;
      addr   <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      pvalid <= '0;
      bcnt   <= '0;
      cidx   <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (busy) begin
        bcnt <= bcnt - 1'b1;
        if (!cidx[PW]) cidx <= cidx + 1'b1;
        if (bcnt == BW'(1)) pvalid <= '0;
      end

      if (start_ev) begin
        st     <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        if (!busy) pvalid <= '0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        if (!busy) begin
          if ((|pvalid) && !wp) begin
            bcnt <= BW'(BUSY_EFF);
            cidx <= '0;
          end else begin
            pvalid <= '0;
          end
        end
      end else if (scl_rise) begin
        if (st == ST_DEV || st == ST_WADR || st == ST_WDAT) begin
          sr  <= {sr[BYTE_W-2:0], sda_in};
          cnt <= cnt + 1'b1;
        end
        if (st == ST_RACK) mack <= !sda_in;
      end else if (scl_fall) begin
        unique case (st)
          ST_DEV: if (cnt == 4'd8) begin
            if (dev_match) begin
              st     <= ST_ACK_DEV;
              sda_oe <= 1'b1;
              rw     <= sr[0];
            end else begin
              st <= ST_IGNORE;
            end
          end
          ST_ACK_DEV: begin
            cnt <= '0;
            if (rw) begin
              st     <= ST_RDAT;
              tx     <= rd_data;
              sda_oe <= !rd_data[BYTE_W-1];
              cnt    <= 4'd1;
            end else begin
              st     <= ST_WADR;
              sda_oe <= 1'b0;
            end
          end
          ST_WADR: if (cnt == 4'd8) begin
            addr   <= sr[AW-1:0];
            st     <= ST_ACK_WADR;
            sda_oe <= 1'b1;
          end
          ST_ACK_WADR, ST_ACK_WDAT: begin
            st     <= ST_WDAT;
            sda_oe <= 1'b0;
            cnt    <= '0;
          end
          ST_WDAT: if (cnt == 4'd8) begin
            st  <= ST_ACK_WDAT;
            cnt <= '0;
            if (!wp) begin
              pbuf[addr[PW-1:0]]   <= sr;
              pvalid[addr[PW-1:0]] <= 1'b1;
              addr[PW-1:0]         <= addr[PW-1:0] + 1'b1;
              sda_oe               <= 1'b1;
            end
          end
          ST_RDAT: begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
              addr   <= addr + 1'b1;
            end else begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= !tx[BYTE_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (mack) begin
              st     <= ST_RDAT;
              tx     <= rd_data;
              sda_oe <= !rd_data[BYTE_W-1];
              cnt    <= 4'd1;
            end else begin
              st <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r5_no_dev_ack_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st != ST_ACK_DEV));
  a_r8_no_commit_wp: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(wp));
  a_r2_ignore_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE) |-> !sda_oe);
  a_r4_page_row_kept: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK_WDAT && $past(st) == ST_WDAT) |-> addr[AW-1:PW] == $past(addr[AW-1:PW]));
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
  import twi_eeprom_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PW       = 3,
  parameter int BUSY_CYC = 600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic we, busy;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;

  twi_bus_sense u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_eeprom_ctrl #(.AW(AW), .PW(PW), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_in(sda_s),
    .strap(strap_i), .wp(wp_i), .rd_data(rd_data), .rd_addr(rd_addr),
    .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe_o), .busy(busy)
  );

  twi_eeprom_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);
  a_r10_reset_released: assert property (@(posedge clk)
    $past(rst) |-> !sda_oe_o && !busy);
endmodule

// File: tb/twi_eeprom_target_test.sv
`timescale 1ns/1ps
module twi_eeprom_target_test;
  localparam int Q     = 6;
  localparam int BUSY  = 600;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [16];
  int maddr = 0;

  always #2.5 clk = ~clk;

  twi_eeprom_target #(.BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    sda_m = b; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = !b;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 0; i < 8; i++) begin
      bit_in(b);
      v = {v[6:0], b};
    end
    bit_out(!give_ack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  // page write of n bytes from wbuf; model follows R4 / R8
  task automatic page_write(input logic [7:0] a, input int n, input string tag);
    bit ack;
    do_start();
    put_byte(dev(STRAP, 1'b0), ack); check(ack, {tag, " R1 dev ack"}, ack, 1);
    put_byte(a, ack);                check(ack, {tag, " R3 word ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      put_byte(wbuf[k], ack);
      check(ack == !wp, {tag, " R8 data ack"}, ack, !wp);
    end
    do_stop();
    if (!wp) begin
      for (int k = 0; k < n; k++) model[{a[7:3], 3'(a[2:0] + k)}] = wbuf[k];
      maddr = {a[7:3], 3'(a[2:0] + n)};
    end else begin
      maddr = a;
    end
  endtask

  task automatic read_burst(input int n, input string tag);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, v);
      check(v == model[maddr], tag, v, model[maddr]);
      maddr = (maddr + 1) & 8'hFF;
    end
    do_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    bit ack;
    do_start();
    put_byte(dev(STRAP, 1'b0), ack); check(ack, {tag, " R1 dev ack"}, ack, 1);
    put_byte(a, ack);                check(ack, {tag, " R3 word ack"}, ack, 1);
    do_start();
    put_byte(dev(STRAP, 1'b1), ack); check(ack, {tag, " R1 read ack"}, ack, 1);
    maddr = a;
    read_burst(n, tag);
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    do_start();
    put_byte(dev(STRAP, 1'b1), ack); check(ack, {tag, " R1 read ack"}, ack, 1);
    read_burst(n, tag);
  endtask

  task automatic wait_busy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    void'($urandom(32'h1c0ffee));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R10 reset released", sda_oe, 0);

    // R1/R3/R5: byte write then random read
    wbuf[0] = 8'hA5;
    page_write(8'h10, 1, "R5 byte write");
    // R5: device address refused while committing
    do_start();
    put_byte(dev(STRAP, 1'b0), ack);
    check(!ack, "R5 busy nack", ack, 0);
    do_stop();
    wait_busy();
    rand_read(8'h10, 1, "R3 random read");

    // R2: wrong strap and wrong prefix ignored, line stays released
    do_start();
    put_byte(dev(3'b001, 1'b0), ack); check(!ack, "R2 strap mismatch", ack, 0);
    put_byte(8'h00, ack);             check(!ack, "R2 stays released", ack, 0);
    do_stop();
    do_start();
    put_byte(8'hB0 | {4'h0, STRAP, 1'b0}, ack); check(!ack, "R2 prefix mismatch", ack, 0);
    do_stop();

    // R4: ten bytes into a page wrap onto its own start
    for (int k = 0; k < 10; k++) wbuf[k] = 8'h30 + 8'(k);
    page_write(8'h2D, 10, "R4 page wrap");
    wait_busy();
    rand_read(8'h27, 10, "R4 R6 page readback");

    // R6: sequential read wraps 255 -> 0
    for (int k = 0; k < 3; k++) wbuf[k] = 8'hE0 + 8'(k);
    page_write(8'hFD, 3, "R6 top write");
    wait_busy();
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
    page_write(8'h00, 2, "R6 bottom write");
    wait_busy();
    rand_read(8'hFD, 5, "R6 array wrap");
    // R7: current-address read continues after the last byte
    cur_read(2, "R7 current read");
    cur_read(1, "R7 counter kept");

    // R8: write protect
    wp = 1'b1;
    for (int k = 0; k < 3; k++) wbuf[k] = 8'hC3;
    page_write(8'h40, 3, "R8 protected");
    wait_busy();
    wp = 1'b0;
    rand_read(8'h40, 3, "R8 array unchanged");

    // R9: start mid-byte abandons data; no commit without stop
    do_start();
    put_byte(dev(STRAP, 1'b0), ack);
    put_byte(8'h60, ack);
    put_byte(8'h99, ack); check(ack, "R9 data ack before abort", ack, 1);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    do_start();
    put_byte(dev(STRAP, 1'b0), ack); check(ack, "R9 restart ack", ack, 1);
    put_byte(8'h60, ack);
    do_start();
    put_byte(dev(STRAP, 1'b1), ack); check(ack, "R9 read ack", ack, 1);
    get_byte(1'b0, v);
    check(v == model[8'h60], "R9 no commit", v, model[8'h60]);
    do_stop();
    maddr = 8'h61;

    // random mix
    for (int it = 0; it < 18; it++) begin
      int op = $urandom_range(0, 2);
      logic [7:0] a = 8'($urandom_range(0, 255));
      if (op == 0) begin
        int n = $urandom_range(1, 11);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        page_write(a, n, "R4 rand write");
        wait_busy();
      end else if (op == 1) begin
        rand_read(a, $urandom_range(1, 12), "R6 rand read");
      end else begin
        cur_read($urandom_range(1, 4), "R7 rand current");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule